// File: doc/BRIEF.md
# Fractional-N Feedback Divider with Third-Order Noise Shaping

This block sits in the feedback path of a fractional-N phase-locked loop. It works out a fresh whole-number division ratio once per reference step. Over many reference steps these ratios average to `INT + FRAC/MOD`, where the denominator `MOD` may be any value and need not be a power of two. A third-order noise-shaping modulator produces the dither. It is built from three cascaded accumulators that each wrap at `MOD`, and it adds a small signed offset to `INT` on every step.

Each whole-number ratio N is split into a main count B and a swallow count A for a dual-modulus prescaler that sits outside the block. The prescaler's output is the block clock, so one clock cycle is one prescaler output period. The block drives a registered modulus-select line. While that line is high the prescaler divides by P+1, and while it is low the prescaler divides by P. A divide cycle therefore spans P·B + A RF periods. The block marks the first prescaler period of every divide cycle with a feedback pulse.

The modulator advances only on a reference-step strobe. In a locked loop that strobe arrives once per divide cycle. The counters read the modulator's latest ratio, and the prescaler choice, only when a new divide cycle starts.

Top module: `frac_n_divider`

## Requirements
- R1: Over K consecutive divide cycles, the total RF period count T meets |T·MOD − K·(INT·MOD + FRAC)| ≤ K. The average ratio is therefore within 1/MOD of INT + FRAC/MOD, for any MOD ≥ 2 and FRAC < MOD.
- R2: A divide cycle with ratio N lasts B prescaler periods, with B = N >> log2(P) and A = N mod P. `modsel` is high for the first A of those periods and low for the rest. `pre_sel` = 0 selects P = 4 (4/5) and `pre_sel` = 1 selects P = 8 (8/9). The cycle length is P·B + A RF periods.
- R3: Each of the three accumulators stays below the modulus latched at the last modulator step. A change of `mod_val` clears all modulator state on the next step.
- R4: With `frac_val` = 0, a step clears all accumulators and carry delays, and the ratio becomes exactly `int_val`, with no dither.
- R5: `fb_pulse` is high for exactly the first prescaler period of each divide cycle. `modsel` rises only in that period.
- R6: While `ref_tick` is low the modulator does not step, so every divide cycle keeps the last ratio, whatever `int_val`, `frac_val` and `mod_val` do.
- R7: `n_invalid` is high for the whole of a divide cycle whose ratio gives B = 0, B < A, or B > 511. In that case B is clamped into the range 1..511.
- R8: While `rst` is high, `modsel`, `fb_pulse` and `n_invalid` are all 0.
- R9: With FRAC ≠ 0, the per-cycle ratio changes from cycle to cycle and stays within INT−3 .. INT+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock, one edge per prescaler period |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference-step strobe; advances the modulator |
| pre_sel | input | 1 | Prescaler pair: 0 = 4/5, 1 = 8/9 |
| int_val | input | 12 | Integer part of the ratio |
| frac_val | input | 12 | Fraction numerator, below `mod_val` |
| mod_val | input | 12 | Fraction denominator, at least 2 |
| modsel | output | 1 | Prescaler modulus select, high = divide by P+1 |
| fb_pulse | output | 1 | High in the first prescaler period of each divide cycle |
| n_invalid | output | 1 | Current divide cycle's ratio cannot be formed by the counters |

## Verification
The bench counts RF periods per divide cycle and checks the long-run average against the programmed fraction for moduli of 7, 13, 25 and 100. A carry combination with a wrong sign, or an accumulator that wraps at a power of two, would push the error well past one period per cycle. Directed cases check the B/A split for both prescaler pairs, since a swapped split gives the wrong number of periods and the wrong number of high-select periods. They also check that a zero fraction gives constant cycles even after a fractional run has left residue behind. With the strobe held low, changed inputs must leave the cycle length unchanged. The invalid flag is checked for a zero main count, a swallow count larger than the main count, an over-range main count, and its clearing on a valid ratio.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  typedef enum logic {
    PRE_4_5 = 1'b0,
    PRE_8_9 = 1'b1
  } pre_e;

  localparam int SD_ORDER = 3;

  function automatic int unsigned pre_log2(input logic sel);
    return (sel == PRE_8_9) ? 3 : 2;
  endfunction
endpackage

// File: rtl/fnd_acc_stage.sv
module fnd_acc_stage #(
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             clr,
  input  logic [MOD_W-1:0] x,
  input  logic [MOD_W-1:0] modv,
  output logic [MOD_W-1:0] sum_nx,
  output logic [MOD_W-1:0] acc_q,
  output logic             carry
);
  logic [MOD_W:0] raw;

  always_comb begin
    raw    = {1'b0, acc_q} + {1'b0, x};
    carry  = (raw >= {1'b0, modv});
    sum_nx = carry ? MOD_W'(raw - {1'b0, modv}) : raw[MOD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        acc_q <= '0;
    else if (step)  acc_q <= clr ? '0 : sum_nx;
  end
endmodule

// File: rtl/fnd_sd_mod.sv
module fnd_sd_mod #(
  parameter int N_W   = 12,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [N_W-1:0]   int_val,
  input  logic [MOD_W-1:0] frac_val,
  input  logic [MOD_W-1:0] mod_val,
  output logic [N_W-1:0]   n_q
);
  import fnd_pkg::*;
  localparam int NMAX = (1 << N_W) - 1;

  logic [MOD_W-1:0]    chain [SD_ORDER+1];
  logic [MOD_W-1:0]    acc   [SD_ORDER];
  logic [SD_ORDER-1:0] cy;
  logic [MOD_W-1:0]    mod_q;
  logic                c2d, c3d, c3dd;
  logic                clr;
  logic [N_W-1:0]      n_nx;

  assign chain[0] = frac_val;
  assign clr      = (frac_val == '0) || (mod_val != mod_q);

  for (genvar i = 0; i < SD_ORDER; i++) begin : g_stage
    fnd_acc_stage #(.MOD_W(MOD_W)) u_stage (
      .clk   (clk),
      .rst   (rst),
      .step  (step),
      .clr   (clr),
      .x     (chain[i]),
      .modv  (mod_val),
      .sum_nx(chain[i+1]),
      .acc_q (acc[i]),
      .carry (cy[i])
    );

    // R3
    acc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (mod_q != '0) |-> (acc[i] < mod_q));
  end

  always_comb begin
    int off;
    int ns;
    off = int'(cy[0]) + int'(cy[1]) - int'(c2d)
        + int'(cy[2]) - 2 * int'(c3d) + int'(c3dd);
    ns  = int'(int_val) + off;
    if (ns < 0)         ns = 0;
    else if (ns > NMAX) ns = NMAX;
    n_nx = N_W'(ns);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q   <= int_val;
      mod_q <= '0;
      c2d   <= 1'b0;
      c3d   <= 1'b0;
      c3dd  <= 1'b0;
    end else if (step) begin
      mod_q <= mod_val;
      if (clr) begin
        n_q  <= int_val;
        c2d  <= 1'b0;
        c3d  <= 1'b0;
        c3dd <= 1'b0;
      end else begin
        n_q  <= n_nx;
        c2d  <= cy[1];
        c3d  <= cy[2];
        c3dd <= c3d;
      end
    end
  end

  // R3
  last_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clr) |-> (chain[SD_ORDER] < mod_val));

  // R4
  int_only_chk: assert property (@(posedge clk) disable iff (rst)
    (step && frac_val == '0) |=> (n_q == $past(int_val)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(n_q));
endmodule

// File: rtl/fnd_split.sv
module fnd_split #(
  parameter int N_W = 12,
  parameter int B_W = 9,
  parameter int A_W = 3
) (
  input  logic [N_W-1:0] n,
  input  logic           pre_sel,
  output logic [B_W-1:0] b_ld,
  output logic [A_W-1:0] a_ld,
  output logic           bad
);
  import fnd_pkg::*;
  localparam int BMAX = (1 << B_W) - 1;

  logic [N_W-1:0] b_full;
  logic [N_W-1:0] a_full;

  always_comb begin
    b_full = n >> pre_log2(pre_sel);
    a_full = n & N_W'((1 << pre_log2(pre_sel)) - 1);
    a_ld   = a_full[A_W-1:0];
    bad    = (b_full == '0) || (b_full > N_W'(BMAX)) || (b_full < a_full);
    if (b_full == '0)              b_ld = B_W'(1);
    else if (b_full > N_W'(BMAX))  b_ld = B_W'(BMAX);
    else                           b_ld = b_full[B_W-1:0];
  end
endmodule

// File: rtl/fnd_swallow_cnt.sv
module fnd_swallow_cnt #(
  parameter int B_W = 9,
  parameter int A_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [B_W-1:0] b_ld,
  input  logic [A_W-1:0] a_ld,
  input  logic           bad_ld,
  output logic           modsel,
  output logic           fb_pulse,
  output logic           n_invalid,
  output logic           load
);
  logic [B_W-1:0] b_left;
  logic [A_W-1:0] a_left;
  logic [A_W-1:0] a_nx;

  assign load = (b_left == B_W'(1));
  assign a_nx = (a_left == '0) ? '0 : a_left - A_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      b_left    <= B_W'(1);
      a_left    <= '0;
      modsel    <= 1'b0;
      fb_pulse  <= 1'b0;
      n_invalid <= 1'b0;
    end else if (load) begin
      b_left    <= b_ld;
      a_left    <= a_ld;
      modsel    <= (a_ld != '0);
      fb_pulse  <= 1'b1;
      n_invalid <= bad_ld;
    end else begin
      b_left    <= b_left - B_W'(1);
      a_left    <= a_nx;
      modsel    <= (a_nx != '0);
      fb_pulse  <= 1'b0;
    end
  end

  // R5
  fb_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> fb_pulse);

  // R5
  modsel_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(modsel) |-> fb_pulse);

  // R7
  bad_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (load && bad_ld) |=> n_invalid);
endmodule

// File: rtl/frac_n_divider.sv
module frac_n_divider #(
  parameter  int B_W   = 9,
  parameter  int A_W   = 3,
  parameter  int MOD_W = 12,
  localparam int N_W   = B_W + A_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             pre_sel,
  input  logic [N_W-1:0]   int_val,
  input  logic [MOD_W-1:0] frac_val,
  input  logic [MOD_W-1:0] mod_val,
  output logic             modsel,
  output logic             fb_pulse,
  output logic             n_invalid
);
  logic [N_W-1:0] n_cur;
  logic [B_W-1:0] b_ld;
  logic [A_W-1:0] a_ld;
  logic           bad_ld;
  logic           load;

  fnd_sd_mod #(.N_W(N_W), .MOD_W(MOD_W)) u_mod (
    .clk     (clk),
    .rst     (rst),
    .step    (ref_tick),
    .int_val (int_val),
    .frac_val(frac_val),
    .mod_val (mod_val),
    .n_q     (n_cur)
  );

  fnd_split #(.N_W(N_W), .B_W(B_W), .A_W(A_W)) u_split (
    .n      (n_cur),
    .pre_sel(pre_sel),
    .b_ld   (b_ld),
    .a_ld   (a_ld),
    .bad    (bad_ld)
  );

  fnd_swallow_cnt #(.B_W(B_W), .A_W(A_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .b_ld     (b_ld),
    .a_ld     (a_ld),
    .bad_ld   (bad_ld),
    .modsel   (modsel),
    .fb_pulse (fb_pulse),
    .n_invalid(n_invalid),
    .load     (load)
  );

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!modsel && !n_invalid && !fb_pulse));
endmodule

// File: tb/frac_n_divider_tb.sv
module frac_n_divider_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b1;
  logic        ref_tick;
  logic        pre_sel = 1'b0;
  logic [11:0] int_val = 12'd40;
  logic [11:0] frac_val = 12'd0;
  logic [11:0] mod_val = 12'd7;
  logic        modsel, fb_pulse, n_invalid;

  int checks = 0;
  int failures = 0;
  longint m_total;
  int m_min, m_max, m_clks, m_ms;

  always #10 clk = ~clk;
  assign ref_tick = fb_pulse & tick_en;

  frac_n_divider u_dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .pre_sel(pre_sel),
    .int_val(int_val), .frac_val(frac_val), .mod_val(mod_val),
    .modsel(modsel), .fb_pulse(fb_pulse), .n_invalid(n_invalid)
  );

  // bits: [36] prescaler select, [35:24] INT, [23:12] FRAC, [11:0] MOD
  localparam logic [36:0] VEC [4] = '{
    {1'b0, 12'd41,  12'd3,  12'd7},
    {1'b1, 12'd100, 12'd11, 12'd25},
    {1'b0, 12'd60,  12'd37, 12'd100},
    {1'b1, 12'd75,  12'd6,  12'd13}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int k);
    int n = 0;
    int cur, clks, ms;
    int pw;
    pw = pre_sel ? 8 : 4;
    m_total = 0; m_min = 1 << 30; m_max = 0;
    @(negedge clk);
    while (!fb_pulse) @(negedge clk);
    cur = pw + int'(modsel); clks = 1; ms = int'(modsel);
    while (n < k) begin
      @(negedge clk);
      if (fb_pulse) begin
        m_total += cur;
        if (cur < m_min) m_min = cur;
        if (cur > m_max) m_max = cur;
        m_clks = clks; m_ms = ms;
        n++;
        cur = 0; clks = 0; ms = 0;
      end
      cur += pw + int'(modsel); clks++; ms += int'(modsel);
    end
  endtask

  task automatic setup(input logic p, input int iv, input int fv, input int mv);
    @(negedge clk);
    pre_sel = p; int_val = 12'(iv); frac_val = 12'(fv); mod_val = 12'(mv);
    measure(4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R8: outputs quiet during reset
    check(!modsel && !fb_pulse && !n_invalid, "R8 reset outputs",
          {modsel, fb_pulse, n_invalid}, 0);
    @(negedge clk); rst = 1'b0;

    // R1 / R9 table walk
    foreach (VEC[i]) begin
      int iv, fv, mv;
      longint err;
      iv = int'(VEC[i][35:24]); fv = int'(VEC[i][23:12]); mv = int'(VEC[i][11:0]);
      setup(VEC[i][36], iv, fv, mv);
      measure(600);
      err = m_total * mv - 600 * (longint'(iv) * mv + fv);
      if (err < 0) err = -err;
      check(err <= 600, "R1 average ratio error", err, 600);
      check(m_min >= iv - 3 && m_max <= iv + 4 && m_min != m_max,
            "R9 dither span", m_max * 10000 + m_min, (iv + 4) * 10000 + iv - 3);
    end

    // R2 / R4: integer ratio after fractional residue, 4/5 pair
    setup(1'b0, 23, 0, 7);
    measure(5);
    check(m_clks == 5, "R2 main count P=4", m_clks, 5);
    check(m_ms == 3, "R2 swallow count P=4", m_ms, 3);
    check(m_min == 23 && m_max == 23, "R4 integer cycle length", m_max, 23);
    // R5: pulse lasts one prescaler period
    @(negedge clk);
    while (!fb_pulse) @(negedge clk);
    @(negedge clk);
    check(!fb_pulse, "R5 fb_pulse width", fb_pulse, 0);

    // R2 with 8/9 pair
    setup(1'b1, 77, 0, 13);
    measure(5);
    check(m_clks == 9, "R2 main count P=8", m_clks, 9);
    check(m_ms == 5, "R2 swallow count P=8", m_ms, 5);
    check(m_min == 77 && m_max == 77, "R2 cycle length P=8", m_max, 77);

    // R6: strobe held low freezes the ratio
    setup(1'b0, 50, 0, 7);
    @(negedge clk); tick_en = 1'b0;
    int_val = 12'd41; frac_val = 12'd5; mod_val = 12'd9;
    measure(30);
    check(m_min == 50 && m_max == 50, "R6 frozen ratio", m_max, 50);
    @(negedge clk); tick_en = 1'b1;

    // R7: invalid ratios
    setup(1'b0, 6, 0, 7);
    check(n_invalid, "R7 B<A flag", n_invalid, 1);
    setup(1'b0, 5, 0, 7);
    check(!n_invalid, "R7 valid clears flag", n_invalid, 0);
    setup(1'b0, 3, 0, 7);
    check(n_invalid, "R7 B=0 flag", n_invalid, 1);
    setup(1'b0, 2100, 0, 7);
    check(n_invalid, "R7 B over range flag", n_invalid, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule